// File: doc/BRIEF.md
# Asynchronous SRAM byte-lane controller

This block connects a clocked host to an external asynchronous static RAM of 262144 words by 16 bits. The RAM has separate active-low enables for its low and high byte. The host places a request on a simple request/acknowledge port. The request carries an 18-bit word address, 16 bits of write data, a 2-bit byte mask and a read/write flag. The controller then runs one access on the memory pins. It holds the access for a fixed number of clocks, set by a parameter, so that the RAM's minimum cycle time of 45 ns is met.

Each access holds chip enable low for `CYCLES` clocks. By default `CYCLES` is 6, which gives 48 ns at 125 MHz. Address and byte enables stay constant for the whole access. On a write, write enable is pulsed low inside the chip-enable window, with one clock of margin on each side. The controller drives the data bus only during that pulse. On a read, output enable is held low for the whole access. The data bus is captured on the last clock, and lanes whose mask bit is clear are returned as zero. The data bus is split into separate input, output and output-enable ports, so the tristate buffer sits outside the block.

The host raises `req` with stable fields and keeps it high until `ack` pulses for one clock. It must drop `req` in the clock that follows. A request that is still high at that point starts a new access.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_be_n` is 2'b11, `mem_dq_oe` is 0 and `ack` is 0.
- R2: Every access holds `mem_ce_n` low for exactly `CYCLES` consecutive clocks. During those clocks `mem_addr` equals the requested address and `mem_be_n` is constant.
- R3: A write with a nonzero mask drives `mem_we_n` low for `CYCLES`-2 clocks, from the second through the second-to-last clock of the chip-enable window. On a read, `mem_we_n` stays high.
- R4: `mem_dq_oe` is 1 only while `mem_we_n` is 0, and then `mem_dq_out` equals the write data. The bus is never driven while `mem_oe_n` is 0.
- R5: A read holds `mem_oe_n` low for the whole chip-enable window. A write keeps it high.
- R6: `ack` is high for exactly one clock, in the clock right after the last chip-enable clock. `rd_data` is valid in that clock and keeps its value until the next read completes.
- R7: Byte mask bit 0 selects data bits 7:0 and drives `mem_be_n[0]` low. Bit 1 selects bits 15:8 and drives `mem_be_n[1]` low. A write changes only the selected stored bytes.
- R8: On a read, each `rd_data` lane whose mask bit is clear is zero. Each selected lane holds the stored byte.
- R9: A request with mask 2'b00 completes with `ack` but never lowers `mem_be_n` or `mem_we_n`, never drives the bus and leaves memory unchanged.
- R10: In the clock where `ack` is high, `mem_ce_n`, `mem_oe_n` and both byte enables are already back high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Request, held until ack |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Byte mask, bit 0 low byte, bit 1 high byte |
| ack | output | 1 | One-clock completion pulse |
| rd_data | output | 16 | Read result, unselected lanes zero |
| mem_addr | output | 18 | RAM address |
| mem_ce_n | output | 1 | RAM chip enable, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_be_n | output | 2 | RAM byte enables, bit 0 low byte, active low |
| mem_dq_out | output | 16 | Data driven toward the RAM |
| mem_dq_oe | output | 1 | Enable of the external bus driver |
| mem_dq_in | input | 16 | Data seen on the RAM bus |

## Verification
The bench's memory model floats unselected read lanes to a nonzero pattern. A controller that forgot to mask disabled lanes would return that pattern in place of zero. The model commits writes only to lanes whose enable is low, so a controller that widened a byte write would corrupt the neighbouring byte, and a later full-word read exposes it. Mask 00 requests and writes to the lowest and highest addresses are aimed at controllers that still pulse write enable or wrap the address. A per-clock watch on write enable, chip enable and the bus driver catches a strobe without setup or hold margin and any overlap of the two drivers.

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16,
  parameter int CYCLES = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_mask,
  output logic              ack,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [1:0]        mem_be_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int LANE_W = DATA_W / 2;
  localparam int CNT_W  = $clog2(CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

  logic              active;
  logic              is_wr;
  logic [CNT_W-1:0]  cnt;
  logic [1:0]        mask_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] lane_keep;

  assign lane_keep  = {{LANE_W{mask_q[1]}}, {LANE_W{mask_q[0]}}};
  assign mem_dq_out = wdata_q;
  assign mem_dq_oe  = ~mem_we_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      is_wr    <= 1'b0;
      cnt      <= '0;
      mask_q   <= 2'b00;
      wdata_q  <= '0;
      mem_addr <= '0;
      mem_ce_n <= 1'b1;
      mem_oe_n <= 1'b1;
      mem_we_n <= 1'b1;
      mem_be_n <= 2'b11;
      ack      <= 1'b0;
      rd_data  <= '0;
    end else begin
      ack <= 1'b0;
      if (!active) begin
        if (req) begin
          active   <= 1'b1;
          cnt      <= '0;
          is_wr    <= req_write;
          mask_q   <= req_mask;
          wdata_q  <= req_wdata;
          mem_addr <= req_addr;
          mem_ce_n <= 1'b0;
          mem_oe_n <= req_write;
          mem_be_n <= ~req_mask;
        end
      end else begin
        cnt <= cnt + 1'b1;
        if (cnt == '0 && is_wr && mask_q != 2'b00)
          mem_we_n <= 1'b0;
        if (cnt == LAST - 1'b1)
          mem_we_n <= 1'b1;
        if (cnt == LAST) begin
          active   <= 1'b0;
          mem_ce_n <= 1'b1;
          mem_oe_n <= 1'b1;
          mem_be_n <= 2'b11;
          ack      <= 1'b1;
          if (!is_wr)
            rd_data <= mem_dq_in & lane_keep;
        end
      end
    end
  end
endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
  parameter int CYCLES = 6
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ack,
  input logic       mem_ce_n,
  input logic       mem_oe_n,
  input logic       mem_we_n,
  input logic [1:0] mem_be_n,
  input logic       mem_dq_oe,
  input logic [17:0] mem_addr
);
  logic [15:0] ce_run;

  always_ff @(posedge clk) begin
    if (!rst_n)         ce_run <= '0;
    else if (!mem_ce_n) ce_run <= ce_run + 1'b1;
    else                ce_run <= '0;
  end

  // R2
  ce_window_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ce_n) |-> ce_run == 16'(CYCLES));

  // R2
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> ($stable(mem_addr) && $stable(mem_be_n)));

  // R3
  we_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> $past(!mem_ce_n));

  // R3
  we_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> !mem_ce_n);

  // R4
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  // R6
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  // R9
  masked_no_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_be_n == 2'b11) |-> mem_we_n);

  // R10
  ack_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (mem_ce_n && mem_oe_n && mem_be_n == 2'b11));
endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(.CYCLES(CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack(ack), .mem_ce_n(mem_ce_n),
  .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_be_n(mem_be_n),
  .mem_dq_oe(mem_dq_oe), .mem_addr(mem_addr)
);

// File: tb/sram_lane_ctrl_bench.sv
`timescale 1ns/1ps
module sram_lane_ctrl_bench;
  localparam int CYC = 6;
  localparam logic [15:0] FLOAT = 16'hA5C3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, req_write = 1'b0;
  logic [17:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0] req_mask = 2'b00;
  logic ack;
  logic [15:0] rd_data, mem_dq_out, mem_dq_in;
  logic [17:0] mem_addr;
  logic mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [1:0] mem_be_n;

  always #4 clk = ~clk;

  sram_lane_ctrl #(.CYCLES(CYC)) u_sram_lane_ctrl (
    .clk(clk), .rst_n(rst_n), .req(req), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .ack(ack), .rd_data(rd_data), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_be_n(mem_be_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  int checks = 0;
  int errors = 0;
  int contention = 0;

  task automatic check(input bit ok, input string req_tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
    end
  endtask

  function automatic logic [15:0] init_word(input logic [17:0] a);
    return a[15:0] ^ 16'h5A5A ^ {a[17:16], 14'b0};
  endfunction

  // memory model
  logic [15:0] mem_arr [int];
  logic [15:0] mem_rd_q = '0;
  logic [1:0]  mem_drv = 2'b00;
  logic        pend = 1'b0;
  logic [17:0] p_addr = '0;
  logic [1:0]  p_be_n = 2'b11;
  logic [15:0] p_data = '0;

  function automatic logic [15:0] mem_word(input logic [17:0] a);
    return mem_arr.exists(int'(a)) ? mem_arr[int'(a)] : init_word(a);
  endfunction

  always_comb begin
    for (int i = 0; i < 2; i++)
      mem_dq_in[i*8 +: 8] = mem_dq_oe ? mem_dq_out[i*8 +: 8] :
                            mem_drv[i] ? mem_rd_q[i*8 +: 8] : FLOAT[i*8 +: 8];
  end

  always @(negedge clk) begin
    logic rd_on;
    logic [15:0] w;
    rd_on = !mem_ce_n && !mem_oe_n && mem_we_n;
    mem_drv  <= rd_on ? ~mem_be_n : 2'b00;
    mem_rd_q <= mem_word(mem_addr);
    if (mem_dq_oe && rd_on && mem_be_n != 2'b11) contention++;
    if (!mem_ce_n && !mem_we_n) begin
      pend <= 1'b1; p_addr <= mem_addr; p_be_n <= mem_be_n; p_data <= mem_dq_in;
    end else if (pend) begin
      w = mem_word(p_addr);
      if (!p_be_n[0]) w[7:0]  = p_data[7:0];
      if (!p_be_n[1]) w[15:8] = p_data[15:8];
      mem_arr[int'(p_addr)] = w;
      pend <= 1'b0;
    end
  end

  // expected model
  logic [15:0] exp_arr [int];

  function automatic logic [15:0] exp_word(input logic [17:0] a);
    return exp_arr.exists(int'(a)) ? exp_arr[int'(a)] : init_word(a);
  endfunction

  function automatic logic [15:0] lane_mask(input logic [1:0] m);
    return {{8{m[1]}}, {8{m[0]}}};
  endfunction

  task automatic do_op(input bit wr, input logic [17:0] a, input logic [15:0] d, input logic [1:0] m);
    int cyc, ce_run, we_run, we_first, oe_low;
    bit stab_ok, bus_ok;
    logic [1:0] be_or;
    logic [15:0] exp_rd;
    exp_rd = exp_word(a) & lane_mask(m);
    @(negedge clk);
    req = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
    cyc = 0; ce_run = 0; we_run = 0; we_first = -1; oe_low = 0;
    be_or = 2'b00; stab_ok = 1'b1; bus_ok = 1'b1;
    forever begin
      @(negedge clk);
      cyc++;
      if (!mem_ce_n) begin
        ce_run++;
        if (mem_addr != a || mem_be_n != ~m) stab_ok = 1'b0;
      end
      if (!mem_we_n) begin
        we_run++;
        if (we_first < 0) we_first = ce_run;
      end
      if (mem_dq_oe != !mem_we_n) bus_ok = 1'b0;
      if (mem_dq_oe && mem_dq_out != d) bus_ok = 1'b0;
      be_or |= ~mem_be_n;
      if (!mem_oe_n) oe_low++;
      if (ack || cyc > 40) break;
    end
    req = 1'b0;
    check(ack, "R6 ack seen", 32'(ack), 1);
    check(cyc == CYC + 1, "R6 ack latency", 32'(cyc), 32'(CYC + 1));
    check(ce_run == CYC, "R2 ce window", 32'(ce_run), 32'(CYC));
    check(stab_ok, "R2 addr/be stable", 32'(stab_ok), 1);
    check(bus_ok, "R4 bus drive only under we", 32'(bus_ok), 1);
    check(mem_ce_n && mem_oe_n && mem_be_n == 2'b11, "R10 released at ack",
          {29'b0, mem_ce_n, mem_be_n}, 32'h7);
    if (m == 2'b00) begin
      check(be_or == 2'b00 && we_run == 0, "R9 mask 00 inert", {be_or, 30'(we_run)}, 0);
    end else begin
      check(be_or == m, "R7 byte enables", 32'(be_or), 32'(m));
    end
    if (wr) begin
      check(oe_low == 0, "R5 oe high on write", 32'(oe_low), 0);
      if (m != 2'b00) begin
        check(we_run == CYC - 2, "R3 we width", 32'(we_run), 32'(CYC - 2));
        check(we_first == 2, "R3 we setup", 32'(we_first), 2);
      end
      exp_arr[int'(a)] = (exp_word(a) & ~lane_mask(m)) | (d & lane_mask(m));
    end else begin
      check(we_run == 0, "R3 we high on read", 32'(we_run), 0);
      check(oe_low == CYC, "R5 oe window", 32'(oe_low), 32'(CYC));
      check(rd_data == exp_rd, "R8 read data", 32'(rd_data), 32'(exp_rd));
    end
    @(negedge clk);
    check(!ack, "R6 ack one clock", 32'(ack), 0);
    if (!wr) check(rd_data == exp_rd, "R6 rd_data held", 32'(rd_data), 32'(exp_rd));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [17:0] pool [8];
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(mem_ce_n && mem_oe_n && mem_we_n && mem_be_n == 2'b11 && !mem_dq_oe && !ack,
          "R1 reset idle", {26'b0, mem_ce_n, mem_oe_n, mem_we_n, mem_be_n, ack}, 32'h3E);
    // directed corners
    do_op(1, 18'h00000, 16'h1234, 2'b11);
    do_op(1, 18'h3FFFF, 16'hBEEF, 2'b11);
    do_op(0, 18'h00000, 16'h0, 2'b11);
    do_op(0, 18'h3FFFF, 16'h0, 2'b11);
    do_op(1, 18'h00010, 16'hAAC1, 2'b01);   // R7 low lane only
    do_op(1, 18'h00011, 16'hC2BB, 2'b10);   // R7 high lane only
    do_op(0, 18'h00010, 16'h0, 2'b11);
    do_op(0, 18'h00011, 16'h0, 2'b11);
    do_op(0, 18'h00010, 16'h0, 2'b01);      // R8 high lane zero
    do_op(0, 18'h00011, 16'h0, 2'b10);      // R8 low lane zero
    do_op(1, 18'h00000, 16'hFFFF, 2'b00);   // R9 no change
    do_op(0, 18'h00000, 16'h0, 2'b11);
    do_op(0, 18'h00020, 16'h0, 2'b00);      // R8 both lanes zero
    // random traffic
    for (int i = 0; i < 8; i++) pool[i] = 18'($urandom);
    pool[0] = 18'h00000; pool[7] = 18'h3FFFF;
    for (int i = 0; i < 400; i++) begin
      do_op(1'($urandom), pool[$urandom % 8], 16'($urandom), 2'($urandom));
    end
    check(contention == 0, "R4 bus contention", 32'(contention), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule